// File: doc/BRIEF.md
# Cascadable LCD Column Drive Latch

This block is the digital core of a dot-matrix LCD column driver. Display data arrives on a narrow bus, one word per falling edge of a capture strobe. Each word is written into a row buffer as wide as the output count (320 by default) while the chip's chain input is active. When the row buffer is full, the chip drives its chain output active, so the next chip in a cascade starts taking data. A falling edge of a line strobe copies the whole row into an output latch and restarts the fill.

Every output carries a 2-bit drive-level code. The code comes from the latched data bit, the AC phase input and a blanking input, and selects an analog level switch outside this block. The bus can be 8 or 4 bits wide. The fill order can be reversed. A reduced mode loads only a middle window of outputs and holds the rest at the not-selected level.

The strobes are plain inputs sampled on `clk`, and a fall is a sample of 0 that follows a sample of 1. The data interface has no back-pressure. A word offered while the chip is disabled or full is dropped without any indication. The chain output is the only flow signal.

Top module: `lcd_seg_latch`

## Requirements
- R1: On each capture-strobe fall with `chain_in_n` low and the row not full, the block takes 8 bits `din[7:0]` when `bus_wide`=1, or 4 bits `din[3:0]` when `bus_wide`=0. The upper nibble is ignored in 4-bit mode.
- R2: With `rev_order`=0, the k-th bit taken in a row goes to output index base+k. Bit 0 of a word is taken first. Output index p is `seg_code[2p+1:2p]`. The base is 0 in full mode and WIN_LO (40) in reduced mode.
- R3: With `rev_order`=1, the k-th bit taken goes to output index base+C-1-k, where C is the row capacity.
- R4: With `full_width`=0, C is WIN_CNT (240) and only indices 40..279 carry data. Every other output shows the not-selected code for the current `ac_phase`.
- R5: `chain_out_n` goes low one `clk` edge after the capture-strobe fall that fills the last position, and no earlier. Later capture falls are ignored until a line-strobe fall.
- R6: On a line-strobe fall, the row buffer is copied into the output latch, and `seg_code` reflects it after that `clk` edge. The same fall clears the fill position and returns `chain_out_n` high. If both strobes fall in the same sample, the line fall wins and the capture is dropped.
- R7: Codes are 00 for the middle level, 01 for V0 and 10 for V1. A selected output (bit 1) shows 01 when `ac_phase`=1 and 10 when `ac_phase`=0. A not-selected output (bit 0) shows the opposite code. Code 11 never appears.
- R8: While `blank_n` is low, every output shows 00 whatever the latched data.
- R9: While `chain_in_n` is high, capture falls change neither the row buffer nor the fill position.
- R10: After reset, `chain_out_n` is high and the output latch holds all zeros, so every output shows the not-selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_strobe | input | 1 | Capture strobe, data taken on its fall |
| line_strobe | input | 1 | Line strobe, row latched on its fall |
| din | input | 8 | Display data word |
| bus_wide | input | 1 | 1: 8-bit words, 0: 4-bit words |
| rev_order | input | 1 | 1: reversed fill order |
| full_width | input | 1 | 1: all outputs, 0: middle window only |
| ac_phase | input | 1 | AC drive phase |
| blank_n | input | 1 | Low forces all outputs to the middle level |
| chain_in_n | input | 1 | Active-low enable from the previous chip |
| chain_out_n | output | 1 | Active-low enable to the next chip, low when full |
| seg_code | output | 2*N_OUT | Per-output drive-level codes |

## Verification
The bench goes after the exact capture that fills a row in all four width and bus combinations. A design that counted the capacity wrongly would move `chain_out_n` one word early or late. It would also accept or lose the extra word written after the row is full.

Reversed and windowed fills are compared output by output. This catches an off-by-one in the window base or the mirror arithmetic, which would misplace whole rows by one position. Other directed cases cover these points:
- a capture that falls in the same sample as a line fall, where a wrong priority would leave a stale fill position;
- a disabled chain input, where a leaking design would overwrite the row;
- the AC and blanking inputs, where wrong polarity would swap V0 and V1.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  typedef enum logic [1:0] {
    LVL_MID = 2'b00,
    LVL_V0  = 2'b01,
    LVL_V1  = 2'b10
  } drive_lvl_e;

  // Selected pixels take V0 when the AC phase is high; unselected take the other rail.
  function automatic logic [1:0] drive_code(input logic sel, input logic ac, input logic on);
    if (!on) return LVL_MID;
    return (sel == ac) ? LVL_V0 : LVL_V1;
  endfunction

endpackage

// File: rtl/seg_fall_det.sv
module seg_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic prev_q;

  // Reset to 0 so a strobe already low at reset release is not taken as a fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign fall = prev_q & ~strobe;
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int N_OUT   = 320,
  parameter int WIN_CNT = 240,
  parameter int PTR_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_fall,
  input  logic             line_fall,
  input  logic             chain_in_n,
  input  logic             bus_wide,
  input  logic             full_width,
  output logic             take,
  output logic [PTR_W-1:0] ptr,
  output logic             chain_out_n
);
  logic             full_q;
  logic [PTR_W-1:0] cap_sz;
  logic [PTR_W-1:0] step;
  logic [PTR_W-1:0] nxt;

  assign cap_sz = full_width ? PTR_W'(N_OUT) : PTR_W'(WIN_CNT);
  assign step   = bus_wide ? PTR_W'(8) : PTR_W'(4);
  assign nxt    = ptr + step;

  // A line fall in the same sample pre-empts the capture (R6).
  assign take   = cap_fall & ~line_fall & ~chain_in_n & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      full_q <= 1'b0;
    end else if (line_fall) begin
      ptr    <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      ptr    <= nxt;
      full_q <= (nxt >= cap_sz);
    end
  end

  assign chain_out_n = ~full_q;
endmodule

// File: rtl/seg_row_store.sv
module seg_row_store #(
  parameter int N_OUT   = 320,
  parameter int WIN_LO  = 40,
  parameter int WIN_CNT = 240,
  parameter int PTR_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [PTR_W-1:0] ptr,
  input  logic [7:0]       din,
  input  logic             bus_wide,
  input  logic             full_width,
  input  logic             rev_order,
  output logic [N_OUT-1:0] row
);
  for (genvar p = 0; p < N_OUT; p++) begin : g_pos
    // Fill index that lands on this output for each mode/order combination.
    localparam int  K_FULL_FWD = p;
    localparam int  K_FULL_REV = N_OUT - 1 - p;
    localparam int  K_WIN_FWD  = p - WIN_LO;
    localparam int  K_WIN_REV  = WIN_LO + WIN_CNT - 1 - p;
    localparam bit  IN_WIN     = (p >= WIN_LO) && (p < WIN_LO + WIN_CNT);

    int   k_i;
    int   off_i;
    logic hit;
    logic nbit;
    logic bit_q;

    always_comb begin
      if (full_width) k_i = rev_order ? K_FULL_REV : K_FULL_FWD;
      else            k_i = rev_order ? K_WIN_REV  : K_WIN_FWD;
      off_i = k_i - int'(ptr);
      hit   = take && (full_width || IN_WIN) && (off_i >= 0) && (off_i < (bus_wide ? 8 : 4));
      nbit  = din[off_i[2:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bit_q <= 1'b0;
      else if (hit) bit_q <= nbit;
    end

    assign row[p] = bit_q;
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import lcd_seg_pkg::*;
#(
  parameter int N_OUT   = 320,
  parameter int WIN_LO  = 40,
  parameter int WIN_CNT = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_fall,
  input  logic [N_OUT-1:0]   row,
  input  logic               full_width,
  input  logic               ac_phase,
  input  logic               blank_n,
  output logic [2*N_OUT-1:0] seg_code
);
  logic [N_OUT-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lat_q <= '0;
    else if (line_fall) lat_q <= row;
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_enc
    localparam bit IN_WIN = (p >= WIN_LO) && (p < WIN_LO + WIN_CNT);
    logic sel;
    assign sel = lat_q[p] & (full_width | IN_WIN);
    assign seg_code[2*p +: 2] = drive_code(sel, ac_phase, blank_n);
  end
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int N_OUT   = 320,
  parameter int WIN_LO  = 40,
  parameter int WIN_CNT = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_strobe,
  input  logic               line_strobe,
  input  logic [7:0]         din,
  input  logic               bus_wide,
  input  logic               rev_order,
  input  logic               full_width,
  input  logic               ac_phase,
  input  logic               blank_n,
  input  logic               chain_in_n,
  output logic               chain_out_n,
  output logic [2*N_OUT-1:0] seg_code
);
  localparam int PTR_W = $clog2(N_OUT + 9);

  logic             cap_fall;
  logic             line_fall;
  logic             take;
  logic [PTR_W-1:0] fill_ptr;
  logic [N_OUT-1:0] row;

  seg_fall_det u_cap_det (
    .clk(clk), .rst_n(rst_n), .strobe(cap_strobe), .fall(cap_fall)
  );

  seg_fall_det u_line_det (
    .clk(clk), .rst_n(rst_n), .strobe(line_strobe), .fall(line_fall)
  );

  seg_fill_ctrl #(.N_OUT(N_OUT), .WIN_CNT(WIN_CNT), .PTR_W(PTR_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .cap_fall(cap_fall), .line_fall(line_fall),
    .chain_in_n(chain_in_n), .bus_wide(bus_wide), .full_width(full_width),
    .take(take), .ptr(fill_ptr), .chain_out_n(chain_out_n)
  );

  seg_row_store #(.N_OUT(N_OUT), .WIN_LO(WIN_LO), .WIN_CNT(WIN_CNT), .PTR_W(PTR_W)) u_row (
    .clk(clk), .rst_n(rst_n), .take(take), .ptr(fill_ptr), .din(din),
    .bus_wide(bus_wide), .full_width(full_width), .rev_order(rev_order), .row(row)
  );

  seg_out_stage #(.N_OUT(N_OUT), .WIN_LO(WIN_LO), .WIN_CNT(WIN_CNT)) u_out (
    .clk(clk), .rst_n(rst_n), .line_fall(line_fall), .row(row),
    .full_width(full_width), .ac_phase(ac_phase), .blank_n(blank_n), .seg_code(seg_code)
  );
endmodule

// File: rtl/lcd_seg_latch_chk.sv
module lcd_seg_latch_chk #(
  parameter int N_OUT   = 320,
  parameter int WIN_LO  = 40,
  parameter int WIN_CNT = 240,
  parameter int PTR_W   = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_strobe,
  input logic               chain_in_n,
  input logic               chain_out_n,
  input logic               blank_n,
  input logic               ac_phase,
  input logic               full_width,
  input logic [PTR_W-1:0]   fill_ptr,
  input logic [2*N_OUT-1:0] seg_code
);
  logic line_q;
  logic line_fall;
  logic codes_legal;
  logic edges_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_strobe;
  end
  assign line_fall = line_q & ~line_strobe;

  always_comb begin
    codes_legal = 1'b1;
    edges_idle  = 1'b1;
    for (int p = 0; p < N_OUT; p++) begin
      if (seg_code[2*p +: 2] == 2'b11) codes_legal = 1'b0;
      if ((p < WIN_LO || p >= WIN_LO + WIN_CNT) &&
          seg_code[2*p +: 2] != (ac_phase ? 2'b10 : 2'b01)) edges_idle = 1'b0;
    end
  end

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> chain_out_n);

  p_hold_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_out_n && !line_fall) |=> !chain_out_n);

  p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ptr <= PTR_W'(N_OUT));

  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_in_n && !line_fall) |=> $stable(fill_ptr));

  p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (seg_code == '0));

  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    codes_legal);

  p_window_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_width && blank_n) |-> edges_idle);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_fall |=> (!($stable(ac_phase) && $stable(blank_n) && $stable(full_width))
                    || $stable(seg_code)));
endmodule

bind lcd_seg_latch lcd_seg_latch_chk #(
  .N_OUT(N_OUT), .WIN_LO(WIN_LO), .WIN_CNT(WIN_CNT), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .chain_in_n(chain_in_n),
  .chain_out_n(chain_out_n), .blank_n(blank_n), .ac_phase(ac_phase),
  .full_width(full_width), .fill_ptr(fill_ptr), .seg_code(seg_code)
);

// File: tb/lcd_seg_latch_tb.sv
module lcd_seg_latch_tb_top;
  localparam int N  = 320;
  localparam int WL = 40;
  localparam int WC = 240;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_strobe = 1'b1, line_strobe = 1'b1;
  logic [7:0] din = '0;
  logic bus_wide = 1'b1, rev_order = 1'b0, full_width = 1'b1;
  logic ac_phase = 1'b1, blank_n = 1'b1, chain_in_n = 1'b0;
  logic chain_out_n;
  logic [2*N-1:0] seg_code;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit mrow[N];
  bit mlat[N];
  int mptr = 0;
  bit mfull = 1'b0;

  always #2 clk = ~clk;

  lcd_seg_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .line_strobe(line_strobe),
    .din(din), .bus_wide(bus_wide), .rev_order(rev_order), .full_width(full_width),
    .ac_phase(ac_phase), .blank_n(blank_n), .chain_in_n(chain_in_n),
    .chain_out_n(chain_out_n), .seg_code(seg_code)
  );

  function automatic int cap_sz();
    return full_width ? N : WC;
  endfunction

  function automatic int step_sz();
    return bus_wide ? 8 : 4;
  endfunction

  function automatic logic [1:0] exp_code(int p);
    bit in_win = full_width || (p >= WL && p < WL + WC);
    bit sel = in_win && mlat[p];
    if (!blank_n) return 2'b00;
    if (sel) return ac_phase ? 2'b01 : 2'b10;
    return ac_phase ? 2'b10 : 2'b01;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_row(string req, string what);
    int bad = -1;
    for (int p = 0; p < N; p++)
      if (bad < 0 && seg_code[2*p +: 2] != exp_code(p)) bad = p;
    if (bad < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, $sformatf("%s at output %0d", what, bad),
             int'(seg_code[2*bad +: 2]), int'(exp_code(bad)));
  endtask

  task automatic cap(logic [7:0] w);
    @(negedge clk);
    din = w;
    cap_strobe = 1'b0;
    if (!chain_in_n && !mfull) begin
      for (int b = 0; b < step_sz(); b++) begin
        int k = mptr + b;
        int base = full_width ? 0 : WL;
        int pos = rev_order ? base + cap_sz() - 1 - k : base + k;
        mrow[pos] = w[b];
      end
      mptr += step_sz();
      mfull = (mptr >= cap_sz());
    end
    @(negedge clk);
    cap_strobe = 1'b1;
  endtask

  task automatic line();
    @(negedge clk);
    line_strobe = 1'b0;
    mlat = mrow;
    mptr = 0;
    mfull = 1'b0;
    @(negedge clk);
    line_strobe = 1'b1;
  endtask

  // Fill a whole row, probe the chain output around the last word, latch and compare.
  task automatic fill_row(string req);
    int n = cap_sz() / step_sz();
    for (int i = 0; i < n; i++) begin
      cap(8'($urandom));
      if (i == n - 2) chk(chain_out_n == 1'b1, "R5", {req, " chain early"}, chain_out_n, 1);
    end
    chk(chain_out_n == 1'b0, "R5", {req, " chain at last word"}, chain_out_n, 0);
    cap(8'($urandom)); // R5: word after full must be dropped
    line();
    check_row(req, "latched row");
    chk(chain_out_n == 1'b1, "R6", {req, " chain release"}, chain_out_n, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(chain_out_n == 1'b1, "R10", "chain after reset", chain_out_n, 1);
    check_row("R10", "outputs after reset");

    // R1 R2 R3 R4: every bus/order/width combination
    for (int c = 0; c < 8; c++) begin
      bus_wide   = c[0];
      rev_order  = c[1];
      full_width = !c[2];
      fill_row(!full_width ? "R4" : (rev_order ? "R3" : "R2"));
    end

    // R1: upper nibble ignored on the narrow bus
    bus_wide = 1'b0; rev_order = 1'b0; full_width = 1'b1;
    for (int i = 0; i < N / 4; i++) cap({4'hF, 4'(i * 5)});
    line();
    check_row("R1", "narrow bus nibble");

    // R7: AC phase flips V0 and V1 on the held row
    ac_phase = 1'b0;
    @(negedge clk);
    check_row("R7", "ac phase low");
    ac_phase = 1'b1;
    @(negedge clk);
    check_row("R7", "ac phase high");

    // R8: blanking
    blank_n = 1'b0;
    @(negedge clk);
    check_row("R8", "blanked");
    blank_n = 1'b1;
    @(negedge clk);
    check_row("R8", "unblanked");

    // R9: disabled chain input drops captures
    bus_wide = 1'b1;
    chain_in_n = 1'b1;
    for (int i = 0; i < 10; i++) cap(8'($urandom));
    chain_in_n = 1'b0;
    line();
    check_row("R9", "row while disabled");
    fill_row("R9");

    // R6: simultaneous falls, line wins
    for (int i = 0; i < 3; i++) cap(8'($urandom));
    @(negedge clk);
    din = 8'hA5;
    cap_strobe = 1'b0;
    line_strobe = 1'b0;
    mlat = mrow; mptr = 0; mfull = 1'b0;
    @(negedge clk);
    cap_strobe = 1'b1;
    line_strobe = 1'b1;
    @(negedge clk);
    check_row("R6", "latch on simultaneous falls");
    fill_row("R6");

    // Random configurations
    for (int r = 0; r < 6; r++) begin
      bus_wide   = 1'($urandom);
      rev_order  = 1'($urandom);
      full_width = 1'($urandom);
      ac_phase   = 1'($urandom);
      fill_row(!full_width ? "R4" : (rev_order ? "R3" : "R2"));
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule